// File: doc/BRIEF.md
# Daisy-Chainable Serial Channel Programmer

This block is a three-wire serial slave that loads 10-bit values into a bank of ten channel registers. A host lowers an active-low select line, clocks in a 16-bit command word most significant bit first on rising serial-clock edges, then raises select. On that rising edge of select the addressed channel register takes the value field, and a mode flag that chooses the downstream refresh clock source is updated from the same word.

The select, serial clock and serial data pins are brought into the system clock domain through two-flop synchronisers, and every serial edge is detected there. A serial data output repeats each received bit on the sixteenth falling serial-clock edge after it came in. Several devices can therefore share select and serial clock, with each output feeding the next device's input. A frame of 16 bits per device then places the first word in the last device, and every device commits when select rises.

Top module: `serial_chan_prog`

## Requirements
- R1: After reset all ten channel registers read 0, the clock-source flag reads 0 (internal), and the serial output is 0.
- R2: While select is low, each rising serial-clock edge shifts serial data into a 16-bit register with the first bit landing in bit 15. When select rises, bits 9:0 are written to the channel that bits 13:10 address (channel A is address 0, slot k of `chan_vals` is bits 10k+9:10k). No register changes without such a commit.
- R3: A committed word sets the clock-source flag to its bit 14 (1 = external, 0 = internal).
- R4: A frame with fewer than 16 rising serial-clock edges changes no channel register and leaves the flag unchanged.
- R5: A frame with more than 16 rising edges commits the last 16 bits received.
- R6: A word whose address is 10 to 15 changes no channel register but still updates the clock-source flag.
- R7: A word whose bit 15 is 1 is ignored completely: no channel register and no flag change.
- R8: Serial-clock edges while select is high shift nothing, move nothing on the serial output and commit nothing.
- R9: The serial output changes only on falling serial-clock edges while select is low. The bit that entered on a given rising edge appears there on the sixteenth falling edge counted from that rising edge.
- R10: In a two-device chain fed a 32-bit frame, the first 16-bit word lands in the second device and the last 16-bit word lands in the first, and both commit on the same rise of select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select; its rise commits the word |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdo | output | 1 | Serial data out toward the next device in a chain |
| ext_clk_sel | output | 1 | Clock-source flag, 1 selects the external refresh clock |
| chan_vals | output | 100 | Ten 10-bit channel registers, channel A in bits 9:0 |

## Verification
The checks assume that the serial pins are slow compared with the system clock. Each level of serial clock, data and select must stay for several system cycles, so that after the synchronisers one edge is seen as one pulse and data is settled at the sampled rising edge. They also assume serial clock is low whenever select changes. The stimulus holds each serial-clock phase for ten system cycles and changes data only in the low phase. It moves select at least four cycles away from any serial-clock edge, and it feeds the second chained device from the first device's real output, so the chain timing rests on the same margins.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned VAL_W  = 10;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned WORD_W = 2 + ADDR_W + VAL_W;

  // Field order is fixed by the serial word: test bit leads, value trails.
  typedef struct packed {
    logic              test_bit;
    logic              ext_clk;
    logic [ADDR_W-1:0] chan;
    logic [VAL_W-1:0]  value;
  } cmd_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/scp_framer.sv
module scp_framer #(
  parameter int unsigned WORD_W = scp_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o,
  output logic              sdo_o,
  output logic              sck_rise_o,
  output logic              sck_fall_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic              sel_q, sck_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic              sdo_q, commit_q;
  logic              sel_fall, sel_rise, rise, fall, full;

  assign sel_fall = sel_q & ~sel_s;
  assign sel_rise = ~sel_q & sel_s;
  assign rise     = ~sel_s & sck_s & ~sck_q;
  assign fall     = ~sel_s & ~sck_s & sck_q;
  assign full     = (cnt_q == CNT_FULL);

  // Edge history of the synchronised pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      sel_q <= sel_s;
      sck_q <= sck_s;
    end
  end

  // Saturating count of rising edges in the current frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sel_fall) begin
      cnt_q <= rise ? CNT_W'(1) : '0;
    end else if (rise && !full) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shift_q <= '0;
    else if (rise) shift_q <= {shift_q[WORD_W-2:0], sdi_s};
  end

  // The oldest stage, relaunched on the falling edge, is the chain output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sdo_q <= 1'b0;
    else if (fall) sdo_q <= shift_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) commit_q <= 1'b0;
    else        commit_q <= sel_rise & full;
  end

  assign word_o     = shift_q;
  assign commit_o   = commit_q;
  assign sdo_o      = sdo_q;
  assign sck_rise_o = rise;
  assign sck_fall_o = fall;
endmodule

// File: rtl/scp_bank.sv
module scp_bank #(
  parameter int unsigned NCH    = 10,
  parameter int unsigned VAL_W  = scp_pkg::VAL_W,
  parameter int unsigned ADDR_W = scp_pkg::ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_i,
  input  scp_pkg::cmd_t        cmd_i,
  output logic [NCH*VAL_W-1:0] vals_o,
  output logic                 ext_clk_o,
  output logic [NCH-1:0]       wr_en_o
);
  logic accept;
  logic ext_q;

  assign accept = commit_i & ~cmd_i.test_bit;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [VAL_W-1:0] val_q;
    assign wr_en_o[c] = accept && (cmd_i.chan == ADDR_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          val_q <= '0;
      else if (wr_en_o[c]) val_q <= cmd_i.value;
    end

    assign vals_o[c*VAL_W +: VAL_W] = val_q;
  end

  // The source flag follows every accepted word, whatever its address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_q <= 1'b0;
    else if (accept) ext_q <= cmd_i.ext_clk;
  end

  assign ext_clk_o = ext_q;
endmodule

// File: rtl/serial_chan_prog.sv
module serial_chan_prog #(
  parameter int unsigned NCH         = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_n,
  input  logic                          sck,
  input  logic                          sdi,
  output logic                          sdo,
  output logic                          ext_clk_sel,
  output logic [NCH*scp_pkg::VAL_W-1:0] chan_vals
);
  localparam int unsigned WORD_W = scp_pkg::WORD_W;

  logic [2:0]        pins_s;
  logic              sel_s, sck_s, sdi_s;
  logic              sck_rise, sck_fall, commit;
  logic [WORD_W-1:0] word;
  scp_pkg::cmd_t     cmd;
  logic [NCH-1:0]    wr_en;

  scp_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({sel_n, sck, sdi}),
    .q_o  (pins_s)
  );

  assign sel_s = pins_s[2];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[0];

  scp_framer #(.WORD_W(WORD_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_s     (sel_s),
    .sck_s     (sck_s),
    .sdi_s     (sdi_s),
    .word_o    (word),
    .commit_o  (commit),
    .sdo_o     (sdo),
    .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall)
  );

  assign cmd = word;

  scp_bank #(
    .NCH   (NCH),
    .VAL_W (scp_pkg::VAL_W),
    .ADDR_W(scp_pkg::ADDR_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit),
    .cmd_i    (cmd),
    .vals_o   (chan_vals),
    .ext_clk_o(ext_clk_sel),
    .wr_en_o  (wr_en)
  );
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int unsigned NCH    = 10,
  parameter int unsigned VAL_W  = 10,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel_s,
  input logic                 sck_fall,
  input logic                 commit,
  input logic [WORD_W-1:0]    word,
  input logic [NCH-1:0]       wr_en,
  input logic                 sdo,
  input logic                 ext_clk_sel,
  input logic [NCH*VAL_W-1:0] chan_vals
);
  logic high_addr;
  assign high_addr = (32'(word[VAL_W +: ADDR_W]) >= NCH);

  p_sdo_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(sdo));

  p_vals_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(chan_vals));

  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  p_flag_on_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ext_clk_sel));

  p_high_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && high_addr |=> $stable(chan_vals));

  p_test_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit && word[WORD_W-1] |=> $stable(chan_vals) && $stable(ext_clk_sel));

  p_idle_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> $stable(word));
endmodule

bind serial_chan_prog scp_checker #(
  .NCH   (NCH),
  .VAL_W (scp_pkg::VAL_W),
  .ADDR_W(scp_pkg::ADDR_W),
  .WORD_W(scp_pkg::WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_s      (sel_s),
  .sck_fall   (sck_fall),
  .commit     (commit),
  .word       (word),
  .wr_en      (wr_en),
  .sdo        (sdo),
  .ext_clk_sel(ext_clk_sel),
  .chan_vals  (chan_vals)
);

// File: tb/test_serial_chan_prog.sv
`timescale 1ns/1ps
module test_serial_chan_prog;
  localparam int NCH = 10;
  localparam int HP  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo_a, sdo_b, ext_a, ext_b;
  logic [NCH*10-1:0] vals_a, vals_b;

  int errors = 0;
  int checks = 0;

  // Bench model of both chained devices.
  logic [15:0] mbsh  [2];
  logic [9:0]  mreg  [2][NCH];
  logic        mmode [2];
  int          mcnt;

  always #2 clk = ~clk;

  serial_chan_prog #(.NCH(NCH)) i_serial_chan_prog (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .sdo(sdo_a), .ext_clk_sel(ext_a), .chan_vals(vals_a)
  );

  serial_chan_prog #(.NCH(NCH)) i_serial_chan_prog_b (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdo_a),
    .sdo(sdo_b), .ext_clk_sel(ext_b), .chan_vals(vals_b)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int dev_val(input int d, input int c);
    return (d == 0) ? int'(vals_a[c*10 +: 10]) : int'(vals_b[c*10 +: 10]);
  endfunction

  task automatic check_all(input string tag);
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < NCH; c++) chk(tag, dev_val(d, c), int'(mreg[d][c]));
    end
    chk({tag, " flag"}, int'(ext_a), int'(mmode[0]));
    chk({tag, " flag"}, int'(ext_b), int'(mmode[1]));
  endtask

  task automatic model_commit();
    for (int d = 0; d < 2; d++) begin
      if (mcnt >= 16 && !mbsh[d][15]) begin
        mmode[d] = mbsh[d][14];
        if (int'(mbsh[d][13:10]) < NCH) mreg[d][mbsh[d][13:10]] = mbsh[d][9:0];
      end
    end
  endtask

  task automatic send(input logic [63:0] bits, input int n);
    logic b_in;
    sel_n = 1'b0;
    mcnt = 0;
    wait_clk(6);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(HP);
      sck = 1'b1;
      b_in = mbsh[0][15];
      mbsh[0] = {mbsh[0][14:0], bits[i]};
      mbsh[1] = {mbsh[1][14:0], b_in};
      mcnt++;
      wait_clk(HP);
      sck = 1'b0;
      wait_clk(6);
      chk("R9 sdo dev0", int'(sdo_a), int'(mbsh[0][15]));
      chk("R9 sdo dev1", int'(sdo_b), int'(mbsh[1][15]));
      wait_clk(HP - 6);
    end
    wait_clk(4);
    sel_n = 1'b1;
    model_commit();
    wait_clk(8);
  endtask

  function automatic logic [15:0] mk(input bit tb, input bit ck, input int a, input int v);
    return {tb, ck, 4'(a), 10'(v)};
  endfunction

  initial begin
    for (int d = 0; d < 2; d++) begin
      mbsh[d] = '0;
      mmode[d] = 1'b0;
      for (int c = 0; c < NCH; c++) mreg[d][c] = '0;
    end
    mcnt = 0;
    void'($urandom(32'h5eed));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);

    // Reset state
    check_all("R1");
    chk("R1 sdo", int'(sdo_a), 0);

    // Plain write to channel C
    send(64'(mk(0, 0, 2, 513)), 16);
    chk("R2 chan2", dev_val(0, 2), 513);
    check_all("R2");

    // Source flag to external on channel H
    send(64'(mk(0, 1, 7, 31)), 16);
    chk("R3 flag", int'(ext_a), 1);
    chk("R3 chan7", dev_val(0, 7), 31);
    check_all("R3");

    // Short frame discarded
    send(64'hABC, 12);
    chk("R4 chan2 kept", dev_val(0, 2), 513);
    check_all("R4");

    // Long frame keeps the last 16 bits
    send({44'h0, 4'hF, mk(0, 0, 0, 1023)}, 20);
    chk("R5 chan0", dev_val(0, 0), 1023);
    check_all("R5");

    // Out-of-range address still moves the flag
    send(64'(mk(0, 0, 12, 77)), 16);
    chk("R6 flag", int'(ext_a), 0);
    check_all("R6");

    // Test bit set: ignored
    send(64'(mk(1, 1, 3, 400)), 16);
    chk("R7 flag", int'(ext_a), 0);
    chk("R7 chan3", dev_val(0, 3), 0);
    check_all("R7");

    // Serial clock toggled while select high
    for (int k = 0; k < 6; k++) begin
      sdi = 1'($urandom);
      wait_clk(HP);
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
    wait_clk(8);
    chk("R8 sdo dev0", int'(sdo_a), int'(mbsh[0][15]));
    chk("R8 sdo dev1", int'(sdo_b), int'(mbsh[1][15]));
    check_all("R8");
    send(64'(mk(0, 0, 5, 300)), 16);
    check_all("R8");

    // Two-device chain, 32-bit frame
    send({32'h0, mk(0, 1, 9, 700), mk(0, 0, 4, 55)}, 32);
    chk("R10 dev1 chan9", dev_val(1, 9), 700);
    chk("R10 dev1 flag", int'(ext_b), 1);
    chk("R10 dev0 chan4", dev_val(0, 4), 55);
    chk("R10 dev0 flag", int'(ext_a), 0);
    check_all("R10");

    // Random frames
    for (int f = 0; f < 40; f++) begin
      int sel, n;
      logic [63:0] bits;
      sel = int'($urandom % 8);
      if (sel < 5)       n = 16;
      else if (sel == 5) n = 32;
      else if (sel == 6) n = 8 + int'($urandom % 8);
      else               n = 17 + int'($urandom % 10);
      bits = {$urandom, $urandom};
      if (($urandom % 8) != 0) begin
        bits[15] = 1'b0;
        bits[31] = 1'b0;
      end
      send(bits, n);
      check_all("R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule